// File: doc/BRIEF.md
# External Bus Address-Strobe Gate

This block sits between the bus timing generator of an 8-bit controller core and the address latch enable pin of its external memory bus. When code runs from on-chip ROM the strobe serves no purpose and only adds switching noise. A single control bit in an auxiliary special-function register lets software silence it.

While the silence bit is set, the gate still opens by itself whenever the core fetches code from external program space or performs an external data or table read. It closes again as soon as the core stops touching external memory. The open/closed decision is taken only on machine-cycle boundaries, so the strobe is never cut in the middle of a pulse. The output is registered and sits low whenever the gate is closed.

Top module: `ale_gate`

## Requirements
- R1: After synchronous reset the silence bit is 0, `ale_out` is 0, `sfr_rdata` is 0 and the gate is open.
- R2: A write strobe at SFR address 0x8E loads `sfr_wdata[0]` into the silence bit. A write at any other address leaves the bit unchanged.
- R3: One cycle after a read strobe at address 0x8E, `sfr_rdata` equals {7'b0, silence bit as held before that edge}. Bits 7..1 always read 0. In any cycle that does not follow a read of 0x8E, `sfr_rdata` is 0.
- R4: With the silence bit at 0, `ale_out` equals `ale_raw` one clock later, on every machine cycle.
- R5: With the silence bit at 1 and no external access sampled at the boundary, `ale_out` stays at 0 for the whole machine cycle.
- R6: With the silence bit at 1, if `ext_fetch` is high at a boundary, the raw pulses of that machine cycle pass to `ale_out`.
- R7: With the silence bit at 1, if `ext_data` is high at a boundary, the raw pulses of that machine cycle pass to `ale_out`.
- R8: The gate decision is sampled only at the clock edge where `mc_start` is high. Input changes after that edge take effect from the next boundary. This includes returning to internal execution, which closes the gate at the next boundary.
- R9: `ale_out` is never high unless `ale_raw` was high one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_rdata | output | 8 | Registered SFR read data |
| mc_start | input | 1 | One-clock strobe marking a machine-cycle boundary |
| ext_fetch | input | 1 | Current code fetch targets external program space |
| ext_data | input | 1 | External data or table access in progress |
| ale_raw | input | 1 | Ungated strobe from the bus timing generator |
| ale_out | output | 1 | Gated, registered address latch enable |

## Verification
The properties take for granted that `mc_start` is a single-clock strobe and that `ale_raw` is low in the boundary clock. Under those conditions every raw pulse falls wholly inside one machine cycle. The stimulus builds each machine cycle as six clocks: the boundary in phase 0 and raw pulses in phases 1, 2 and 4. Register reads and writes are issued in idle clocks between machine cycles, where `ale_raw` is low and no boundary occurs. The access inputs are changed either at the boundary or only after it, to probe the sampling point.

// File: rtl/ale_gate_pkg.sv
package ale_gate_pkg;
  localparam int SFR_AW       = 8;
  localparam int SFR_DW       = 8;
  localparam logic [SFR_AW-1:0] AUX_ADDR_DEF = 8'h8E;
  localparam int SILENCE_BIT  = 0;
endpackage

// File: rtl/aux_sfr.sv
module aux_sfr #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADDR = 8'h8E,
  parameter int BITPOS = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          silence
);
  logic hit;
  assign hit = (addr == ADDR);

  always_ff @(posedge clk) begin
    if (rst)             silence <= 1'b0;
    else if (wr && hit)  silence <= wdata[BITPOS];
  end

  for (genvar b = 0; b < DW; b++) begin : g_rd
    if (b == BITPOS) begin : g_live
      always_ff @(posedge clk) begin
        if (rst) rdata[b] <= 1'b0;
        else     rdata[b] <= rd && hit && silence;
      end
    end else begin : g_zero
      always_ff @(posedge clk) begin
        rdata[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ale_window.sv
module ale_window (
  input  logic clk,
  input  logic rst,
  input  logic boundary,
  input  logic silence,
  input  logic ext_fetch,
  input  logic ext_data,
  output logic open_q
);
  logic want_open;
  assign want_open = !silence || ext_fetch || ext_data;

  always_ff @(posedge clk) begin
    if (rst)           open_q <= 1'b1;
    else if (boundary) open_q <= want_open;
  end
endmodule

// File: rtl/ale_drive.sv
module ale_drive (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic open_q,
  output logic pin
);
  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= raw && open_q;
  end
endmodule

// File: rtl/ale_gate.sv
module ale_gate
  import ale_gate_pkg::*;
#(
  parameter logic [SFR_AW-1:0] AUX_ADDR = AUX_ADDR_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic [SFR_DW-1:0] sfr_wdata,
  input  logic              sfr_wr,
  input  logic              sfr_rd,
  output logic [SFR_DW-1:0] sfr_rdata,
  input  logic              mc_start,
  input  logic              ext_fetch,
  input  logic              ext_data,
  input  logic              ale_raw,
  output logic              ale_out
);
  logic silence_q;
  logic open_q;

  aux_sfr #(
    .AW(SFR_AW), .DW(SFR_DW), .ADDR(AUX_ADDR), .BITPOS(SILENCE_BIT)
  ) u_sfr (
    .clk(clk), .rst(rst), .addr(sfr_addr), .wdata(sfr_wdata),
    .wr(sfr_wr), .rd(sfr_rd), .rdata(sfr_rdata), .silence(silence_q)
  );

  ale_window u_win (
    .clk(clk), .rst(rst), .boundary(mc_start), .silence(silence_q),
    .ext_fetch(ext_fetch), .ext_data(ext_data), .open_q(open_q)
  );

  ale_drive u_drv (
    .clk(clk), .rst(rst), .raw(ale_raw), .open_q(open_q), .pin(ale_out)
  );
endmodule

// File: rtl/ale_gate_chk.sv
module ale_gate_chk
  import ale_gate_pkg::*;
#(
  parameter logic [SFR_AW-1:0] AUX_ADDR = AUX_ADDR_DEF
) (
  input logic              clk,
  input logic              rst,
  input logic [SFR_AW-1:0] sfr_addr,
  input logic [SFR_DW-1:0] sfr_wdata,
  input logic              sfr_wr,
  input logic              sfr_rd,
  input logic [SFR_DW-1:0] sfr_rdata,
  input logic              mc_start,
  input logic              ale_raw,
  input logic              ale_out,
  input logic              silence_q,
  input logic              open_q
);
  // R2
  aux_write_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_wr && sfr_addr == AUX_ADDR) |=> (silence_q == $past(sfr_wdata[SILENCE_BIT])));

  // R3
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sfr_rdata[SFR_DW-1:1] == '0);

  // R3
  rd_value_chk: assert property (@(posedge clk) disable iff (rst)
    (sfr_rd && sfr_addr == AUX_ADDR) |=> (sfr_rdata[0] == $past(silence_q)));

  // R8
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mc_start |=> $stable(open_q));

  // R4
  clear_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_start && !silence_q) |=> open_q);

  // R9
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    !ale_raw |=> !ale_out);
endmodule

bind ale_gate ale_gate_chk #(.AUX_ADDR(AUX_ADDR)) u_ale_gate_chk (
  .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
  .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
  .mc_start(mc_start), .ale_raw(ale_raw), .ale_out(ale_out),
  .silence_q(silence_q), .open_q(open_q)
);

// File: tb/ale_gate_tb_top.sv
`timescale 1ns/1ps
module ale_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic       sfr_wr = 1'b0;
  logic       sfr_rd = 1'b0;
  logic [7:0] sfr_rdata;
  logic       mc_start = 1'b0;
  logic       ext_fetch = 1'b0;
  logic       ext_data = 1'b0;
  logic       ale_raw = 1'b0;
  logic       ale_out;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural reference state
  bit       m_sil = 0;
  bit       m_open = 1;
  bit       m_ale = 0;
  bit [7:0] m_rd = 0;
  string    tag = "R1";

  always #2 clk = ~clk;

  ale_gate dut_i (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_rdata(sfr_rdata),
    .mc_start(mc_start), .ext_fetch(ext_fetch), .ext_data(ext_data),
    .ale_raw(ale_raw), .ale_out(ale_out)
  );

  task automatic compare();
    compared++;
    if (ale_out !== m_ale || sfr_rdata !== m_rd) begin
      mismatched++;
      $display("FAIL %s: ale_out=%0b rdata=%02h expected ale_out=%0b rdata=%02h",
               tag, ale_out, sfr_rdata, m_ale, m_rd);
    end
  endtask

  // one clock: inputs already driven; advance model, then compare at negedge
  task automatic step();
    bit       n_sil, n_open, n_ale;
    bit [7:0] n_rd;
    @(posedge clk);
    n_ale  = ale_raw && m_open;
    n_open = mc_start ? (!m_sil || ext_fetch || ext_data) : m_open;
    n_sil  = (sfr_wr && sfr_addr == 8'h8E) ? sfr_wdata[0] : m_sil;
    n_rd   = (sfr_rd && sfr_addr == 8'h8E) ? {7'b0, m_sil} : 8'h00;
    m_ale = n_ale; m_open = n_open; m_sil = n_sil; m_rd = n_rd;
    @(negedge clk);
    compare();
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    step();
    sfr_wr = 1'b0;
    step();
  endtask

  task automatic sfr_read(input logic [7:0] a);
    sfr_addr = a; sfr_rd = 1'b1;
    step();
    sfr_rd = 1'b0;
    step();
  endtask

  // six-clock machine cycle; access inputs at the boundary vs. afterwards
  task automatic mcycle(input bit f0, input bit d0, input bit f1, input bit d1);
    for (int ph = 0; ph < 6; ph++) begin
      mc_start  = (ph == 0);
      ale_raw   = (ph == 1 || ph == 2 || ph == 4);
      ext_fetch = (ph == 0) ? f0 : f1;
      ext_data  = (ph == 0) ? d0 : d1;
      step();
    end
    mc_start = 1'b0; ale_raw = 1'b0; ext_fetch = 1'b0; ext_data = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step(); step();
    m_sil = 0; m_open = 1; m_ale = 0; m_rd = 0;
    rst = 1'b0;
    tag = "R1"; compare();
    tag = "R3"; sfr_read(8'h8E);
    tag = "R4"; mcycle(0, 0, 0, 0); mcycle(0, 0, 0, 0);
    tag = "R2"; sfr_write(8'h8E, 8'h01);
    tag = "R3"; sfr_read(8'h8E);
    tag = "R3"; sfr_read(8'h8F);
    tag = "R5"; mcycle(0, 0, 0, 0); mcycle(0, 0, 0, 0);
    tag = "R6"; mcycle(1, 0, 1, 0); mcycle(1, 0, 1, 0);
    tag = "R8"; mcycle(0, 0, 0, 0);
    tag = "R7"; mcycle(0, 1, 0, 1);
    tag = "R8"; mcycle(0, 0, 1, 1); mcycle(0, 0, 0, 0);
    tag = "R8"; mcycle(1, 0, 0, 0); mcycle(0, 0, 0, 0);
    tag = "R2"; sfr_write(8'h8D, 8'h00);
    tag = "R5"; mcycle(0, 0, 0, 0);
    tag = "R2"; sfr_write(8'h8E, 8'hFE);
    tag = "R3"; sfr_read(8'h8E);
    tag = "R4"; mcycle(0, 0, 0, 0); mcycle(1, 1, 1, 1);
    tag = "R9"; mcycle(0, 0, 0, 0);
    tag = "R2"; sfr_write(8'h8E, 8'hFF);
    tag = "R3"; sfr_read(8'h8E);
    tag = "R5"; mcycle(0, 0, 0, 0);
    tag = "R1"; rst = 1'b1; step();
    m_sil = 0; m_open = 1; m_ale = 0; m_rd = 0;
    rst = 1'b0; compare();
    tag = "R1"; mcycle(0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule